// File: doc/BRIEF.md
# Idle-Channel Mute Detector

This block watches a stereo sample stream that arrives as one left/right pair per word-select period, marked by a single-cycle valid strobe. When both channels have carried only static values (every bit zero or every bit one) for a long enough unbroken run of pairs, it raises a mute flag that downstream output logic uses to silence the idle channel noise. The first pair that carries real signal on either channel drops the flag in the next cycle.

The function is enabled by an active-low control input. While that input is high the run count is held at zero and the mute flag is forced low in the same cycle, so enabling the feature always starts a fresh full-length run. The run length is a parameter with a default of 8192 pairs; the sample width is a parameter with a default of 20 bits.

Top module: `idle_mute_detector`

## Requirements
- R1: A sample is idle when all of its bits are 0 or all of its bits are 1; a pair is idle only when both channels are idle, and the two channels may hold different static values (for example left all zeros, right all ones).
- R2: While enabled, every strobed idle pair extends the run by one; the mute output goes high in the cycle after the 8192nd consecutive idle pair is strobed and is still low after the 8191st.
- R3: A strobed pair in which either channel is not idle restarts the run at zero; the mute output is low from the cycle after that strobe and a full new run of 8192 idle pairs is needed to set it again.
- R4: While the active-low enable input is high the mute output is low in that same cycle, strobes are ignored, and the run is cleared, so after enabling again 8192 idle pairs are needed.
- R5: The run saturates at 8192 and does not wrap; further idle pairs keep the mute output high.
- R6: Cycles without a valid strobe change neither the run nor the mute output.
- R7: After reset the run is zero and the mute output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pair_valid | input | 1 | One-cycle strobe marking a new left/right pair |
| left_smp | input | 20 | Left channel sample, two's complement |
| right_smp | input | 20 | Right channel sample, two's complement |
| automute_dis | input | 1 | Active-low enable: low turns the detector on, high forces mute off |
| mute | output | 1 | High while the input is judged idle |

## Verification
The embedded assertions check on every cycle that the run never exceeds its limit, that an idle strobe advances it by exactly one, that an active strobe or a disabled cycle clears it, and that cycles without a strobe leave it untouched. Only the bench scenarios show the end-to-end timing: that mute appears exactly after the 8192nd idle pair and not after the 8191st, that mixed static values count as idle, that a single-bit change on one channel drops mute in the next cycle, and that raising the enable input silences the flag in the same cycle.

// File: rtl/idle_mute_pkg.sv
package idle_mute_pkg;
  localparam int unsigned SMP_W_DEF  = 20;
  localparam int unsigned RUN_LEN_DEF = 8192;
  localparam int unsigned NUM_CH     = 2;
endpackage

// File: rtl/idle_rst_sync.sv
module idle_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/idle_sample_check.sv
module idle_sample_check #(
  parameter int unsigned SMP_W = idle_mute_pkg::SMP_W_DEF
) (
  input  logic [SMP_W-1:0] smp,
  output logic             is_static
);
  always_comb begin
    is_static = (smp == {SMP_W{1'b0}}) || (smp == {SMP_W{1'b1}});
  end
endmodule

// File: rtl/idle_run_counter.sv
module idle_run_counter #(
  parameter int unsigned RUN_LEN = idle_mute_pkg::RUN_LEN_DEF,
  localparam int unsigned CW     = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          strobe,
  input  logic          pair_idle,
  output logic          saturated,
  output logic [CW-1:0] run
);
  localparam logic [CW-1:0] LIM = CW'(RUN_LEN);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    run_en = 1'b0;
    run_d  = run_q;
    if (!enable) begin
      run_en = (run_q != '0);
      run_d  = '0;
    end else if (strobe) begin
      run_en = 1'b1;
      if (!pair_idle)       run_d = '0;
      else if (run_q < LIM) run_d = run_q + 1'b1;
      else                  run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign run       = run_q;
  assign saturated = (run_q == LIM);

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIM); // R5
  AST_IDLE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && pair_idle && run_q < LIM) |=> run_q == $past(run_q) + 1'b1); // R2
  AST_ACTIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && !pair_idle) |=> run_q == '0); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> run_q == '0); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q == LIM && !(strobe && !pair_idle)) |=> run_q == LIM); // R5
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !strobe) |=> $stable(run_q)); // R6
endmodule

// File: rtl/idle_mute_detector.sv
module idle_mute_detector #(
  parameter int unsigned SMP_W   = idle_mute_pkg::SMP_W_DEF,
  parameter int unsigned RUN_LEN = idle_mute_pkg::RUN_LEN_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid,
  input  logic [SMP_W-1:0] left_smp,
  input  logic [SMP_W-1:0] right_smp,
  input  logic             automute_dis,
  output logic             mute
);
  localparam int unsigned NCH = idle_mute_pkg::NUM_CH;
  localparam int unsigned CW  = $clog2(RUN_LEN + 1);

  logic                 rst_sync_n;
  logic [NCH-1:0][SMP_W-1:0] ch_smp;
  logic [NCH-1:0]       ch_static;
  logic                 pair_idle;
  logic                 enable;
  logic                 saturated;
  logic [CW-1:0]        run;

  idle_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ch_smp[0] = left_smp;
  assign ch_smp[1] = right_smp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    idle_sample_check #(.SMP_W(SMP_W)) i_check (
      .smp       (ch_smp[c]),
      .is_static (ch_static[c])
    );
  end

  assign pair_idle = &ch_static;
  assign enable    = ~automute_dis;

  idle_run_counter #(.RUN_LEN(RUN_LEN)) i_run (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .strobe    (pair_valid),
    .pair_idle (pair_idle),
    .saturated (saturated),
    .run       (run)
  );

  assign mute = enable & saturated;

  AST_MUTE_RELEASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pair_valid && !automute_dis && (left_smp[0] != left_smp[SMP_W-1])) |=> !mute); // R3
  AST_MUTE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mute) |-> (run == CW'(RUN_LEN))); // R2
endmodule

// File: tb/test_idle_mute_detector.sv
module test_idle_mute_detector;
  localparam int W      = 20;
  localparam int LIMIT  = 8192;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pair_valid;
  logic [W-1:0] left_smp, right_smp;
  logic         automute_dis;
  logic         mute;

  int total = 0;
  int bad   = 0;
  int run   = 0;
  string cur_req = "R7";

  always #(PERIOD/2) clk = ~clk;

  idle_mute_detector #(.SMP_W(W), .RUN_LEN(LIMIT)) i_idle_mute_detector (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .left_smp(left_smp),
    .right_smp(right_smp), .automute_dis(automute_dis), .mute(mute)
  );

  function automatic bit smp_idle(logic [W-1:0] s);
    return (s == '0) || (s == {W{1'b1}});
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: mute=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, compared every clock
  always @(posedge clk) begin
    if (!rst_n || automute_dis) run = 0;
    else if (pair_valid) begin
      if (smp_idle(left_smp) && smp_idle(right_smp)) run = (run < LIMIT) ? run + 1 : run;
      else run = 0;
    end
    #(PERIOD/4);
    check(cur_req, mute, (!automute_dis && run == LIMIT));
  end

  task automatic push(logic [W-1:0] l, logic [W-1:0] r);
    @(negedge clk);
    pair_valid = 1'b1; left_smp = l; right_smp = r;
    @(negedge clk);
    pair_valid = 1'b0;
  endtask

  task automatic push_n(int n, logic [W-1:0] l, logic [W-1:0] r);
    for (int i = 0; i < n; i++) push(l, r);
  endtask

  task automatic mid_check(string req, logic exp);
    @(negedge clk); #1;
    check(req, mute, exp);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run incomplete, expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    rst_n = 1'b0; pair_valid = 1'b0; left_smp = '0; right_smp = '0; automute_dis = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", mute, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7", mute, 1'b0);

    cur_req = "R2";
    push_n(LIMIT - 1, '0, '0);
    mid_check("R2", 1'b0);
    push('0, '0);
    mid_check("R2", 1'b1);

    cur_req = "R5";
    push_n(50, {W{1'b1}}, {W{1'b1}});
    mid_check("R5", 1'b1);

    cur_req = "R6";
    repeat (20) @(negedge clk);
    check("R6", mute, 1'b1);

    cur_req = "R3";
    push(20'h00001, '0);
    mid_check("R3", 1'b0);
    push_n(LIMIT - 1, '0, '0);
    mid_check("R3", 1'b0);
    push(20'h7FFFF, {W{1'b1}});
    push_n(LIMIT, '0, '0);
    mid_check("R3", 1'b1);
    push('0, 20'h80000);
    mid_check("R3", 1'b0);

    cur_req = "R1";
    push_n(LIMIT, '0, {W{1'b1}});
    mid_check("R1", 1'b1);
    push(20'h00100, 20'h00100);
    mid_check("R1", 1'b0);

    cur_req = "R6";
    push_n(LIMIT - 10, {W{1'b1}}, '0);
    repeat (30) @(negedge clk);
    push_n(10, {W{1'b1}}, '0);
    mid_check("R6", 1'b1);

    cur_req = "R4";
    @(negedge clk); automute_dis = 1'b1; #1;
    check("R4", mute, 1'b0);
    push_n(5, '0, '0);
    push(20'h12345, 20'h54321);
    mid_check("R4", 1'b0);
    @(negedge clk); automute_dis = 1'b0;
    push_n(LIMIT - 1, '0, '0);
    mid_check("R4", 1'b0);
    push('0, '0);
    mid_check("R4", 1'b1);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule